// File: doc/BRIEF.md
# Jiffy Uptime and Seconds Counter

This block keeps system time from a periodic jiffy tick that arrives once every 10 ms (100 Hz). Every accepted tick adds one to a 32-bit uptime count of jiffies. A small down-counter divides the tick by 100, and each time it runs out the block adds one to a 48-bit count of seconds since a fixed epoch. The down-counter then starts over.

The host sees the block through a byte-wide register port. A write strobe with a byte address replaces one byte of either live counter. A snapshot strobe copies both live counters into holding registers in one edge. Byte reads are served from the holding registers only. A value read out over several bus cycles therefore never mixes bytes from before and after a tick.

Both counters wrap to zero when they overflow, and each has its own sticky overflow flag. When a host write and a tick fall in the same cycle, the write wins and the tick is lost.

Top module: `jiffy_timekeeper`

## Requirements
- R1: After the asynchronous reset both live counters, both holding registers and both overflow flags are zero, and the jiffy divider is loaded with 100.
- R2: A tick accepted at a clock edge (`tick_i` high, `wr_en_i` low) adds exactly one to the 32-bit uptime counter.
- R3: The seconds counter adds one exactly on the 100th accepted tick since reset or since the last seconds write, and on every 100th accepted tick after that. It does not change on any other tick.
- R4: An accepted tick with the uptime counter at 0xFFFFFFFF makes it 0 and sets `upt_ovf_o`. The flag stays set until reset.
- R5: A seconds increment with the seconds counter at 0xFFFFFFFFFFFF makes it 0 and sets `sec_ovf_o`. The flag stays set until reset.
- R6: A clock edge with `snap_i` high copies the counter values held before that edge into the holding registers. Without `snap_i` the holding registers keep their contents. `rd_data_o` shows byte `rd_addr_i` of the holding registers: addresses 0 to 3 are uptime bytes with the least significant byte first, addresses 4 to 9 are seconds bytes with the least significant byte first, and addresses 10 to 15 read as zero.
- R7: With `wr_en_i` high, `wr_data_i` replaces the live byte at `wr_addr_i`, using the same byte map as R6. Writes to addresses 10 to 15 change nothing.
- R8: A write to any seconds byte (address 4 to 9) reloads the jiffy divider to 100, so the next second comes after 100 further accepted ticks.
- R9: A tick that coincides with `wr_en_i` high, whatever the address, is dropped. Neither counter and not the divider advances for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Jiffy tick pulse, one cycle per 10 ms |
| wr_en_i | input | 1 | Host byte write strobe |
| wr_addr_i | input | 4 | Byte address of the write |
| wr_data_i | input | 8 | Write data byte |
| snap_i | input | 1 | Copy live counters into holding registers |
| rd_addr_i | input | 4 | Byte address of the read |
| rd_data_o | output | 8 | Holding-register byte at `rd_addr_i` |
| upt_ovf_o | output | 1 | Sticky uptime overflow flag |
| sec_ovf_o | output | 1 | Sticky seconds overflow flag |

## Verification
The bench checks the 99th and 100th ticks after reset and after a seconds write. A divider that reloads one tick off, or is not restarted by the write, shows a second appearing one tick early or late. It also snaps in the same cycle as a tick, and then ticks on without snapping. A holding register that takes post-tick values, or follows the live count, reads back the wrong bytes. It ticks during host writes, including writes to unmapped addresses. A design that lets such a tick through, or lets the unmapped write alias onto a counter, changes a count it should leave alone. Finally it presets both counters to all ones. A wrong carry or a flag that clears itself shows up at the wrap.

// File: rtl/jt_pkg.sv
package jt_pkg;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/jt_counter.sv
module jt_counter #(
  parameter int W      = 32,
  parameter int ADDR_W = 4,
  parameter int BASE   = 0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     inc_i,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [jt_pkg::BYTE_W-1:0] wr_data_i,
  output logic [W-1:0]             cnt_o,
  output logic                     hit_o,
  output logic                     ovf_o
);
  import jt_pkg::*;
  localparam int NB = W / BYTE_W;

  logic [W-1:0] cnt_q, cnt_d;
  logic         ovf_q;
  logic [NB-1:0] byte_hit;

  for (genvar b = 0; b < NB; b++) begin : g_hit
    assign byte_hit[b] = wr_en_i && (wr_addr_i == ADDR_W'(BASE + b));
  end

  assign hit_o = |byte_hit;

  always_comb begin
    cnt_d = cnt_q;
    if (hit_o) begin
      for (int b = 0; b < NB; b++)
        if (byte_hit[b]) cnt_d[b*BYTE_W +: BYTE_W] = wr_data_i;
    end else if (inc_i) begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (inc_i && !hit_o && (&cnt_q)) ovf_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/jt_jiffy_div.sv
module jt_jiffy_div #(
  parameter int RELOAD = 100,
  localparam int CNT_W = $clog2(RELOAD + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] div_o,
  output logic             step_o
);
  logic [CNT_W-1:0] div_q;

  // last jiffy of the second: down-counter is about to reach zero
  assign step_o = tick_i && (div_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= CNT_W'(RELOAD);
    else if (restart_i) div_q <= CNT_W'(RELOAD);
    else if (step_o)    div_q <= CNT_W'(RELOAD);
    else if (tick_i)    div_q <= div_q - CNT_W'(1);
  end

  assign div_o = div_q;
endmodule

// File: rtl/jt_snapshot.sv
module jt_snapshot #(
  parameter int UPT_W  = 32,
  parameter int SEC_W  = 48,
  parameter int ADDR_W = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      snap_i,
  input  logic [UPT_W-1:0]          upt_i,
  input  logic [SEC_W-1:0]          sec_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  output logic [jt_pkg::BYTE_W-1:0] rd_data_o,
  output logic [UPT_W-1:0]          snap_upt_o,
  output logic [SEC_W-1:0]          snap_sec_o
);
  import jt_pkg::*;
  localparam int TOT_W = UPT_W + SEC_W;
  localparam int NTOT  = TOT_W / BYTE_W;
  localparam int NADDR = 2 ** ADDR_W;

  logic [UPT_W-1:0]  upt_q;
  logic [SEC_W-1:0]  sec_q;
  logic [TOT_W-1:0]  all_w;
  logic [BYTE_W-1:0] bytes_w [NADDR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upt_q <= '0;
      sec_q <= '0;
    end else if (snap_i) begin
      upt_q <= upt_i;
      sec_q <= sec_i;
    end
  end

  assign all_w = {sec_q, upt_q};

  for (genvar i = 0; i < NADDR; i++) begin : g_map
    if (i < NTOT) begin : g_used
      assign bytes_w[i] = all_w[i*BYTE_W +: BYTE_W];
    end else begin : g_pad
      assign bytes_w[i] = '0;
    end
  end

  assign rd_data_o  = bytes_w[rd_addr_i];
  assign snap_upt_o = upt_q;
  assign snap_sec_o = sec_q;
endmodule

// File: rtl/jiffy_timekeeper.sv
module jiffy_timekeeper #(
  parameter int UPT_W  = 32,
  parameter int SEC_W  = 48,
  parameter int RELOAD = 100,
  parameter int ADDR_W = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tick_i,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [jt_pkg::BYTE_W-1:0] wr_data_i,
  input  logic                      snap_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  output logic [jt_pkg::BYTE_W-1:0] rd_data_o,
  output logic                      upt_ovf_o,
  output logic                      sec_ovf_o
);
  import jt_pkg::*;
  localparam int SEC_BASE = UPT_W / BYTE_W;
  localparam int CNT_W    = $clog2(RELOAD + 1);

  logic             tick_ok;
  logic             sec_step;
  logic             upt_hit, sec_hit;
  logic [UPT_W-1:0] upt_q, snap_upt;
  logic [SEC_W-1:0] sec_q, snap_sec;
  logic [CNT_W-1:0] div_q;

  // host access has priority; a coincident tick is lost
  assign tick_ok = tick_i && !wr_en_i;

  jt_counter #(.W(UPT_W), .ADDR_W(ADDR_W), .BASE(0)) i_upt (
    .clk_i, .rst_ni,
    .inc_i    (tick_ok),
    .wr_en_i,
    .wr_addr_i,
    .wr_data_i,
    .cnt_o    (upt_q),
    .hit_o    (upt_hit),
    .ovf_o    (upt_ovf_o)
  );

  jt_jiffy_div #(.RELOAD(RELOAD)) i_div (
    .clk_i, .rst_ni,
    .tick_i    (tick_ok),
    .restart_i (sec_hit),
    .div_o     (div_q),
    .step_o    (sec_step)
  );

  jt_counter #(.W(SEC_W), .ADDR_W(ADDR_W), .BASE(SEC_BASE)) i_sec (
    .clk_i, .rst_ni,
    .inc_i    (sec_step),
    .wr_en_i,
    .wr_addr_i,
    .wr_data_i,
    .cnt_o    (sec_q),
    .hit_o    (sec_hit),
    .ovf_o    (sec_ovf_o)
  );

  jt_snapshot #(.UPT_W(UPT_W), .SEC_W(SEC_W), .ADDR_W(ADDR_W)) i_snap (
    .clk_i, .rst_ni,
    .snap_i,
    .upt_i      (upt_q),
    .sec_i      (sec_q),
    .rd_addr_i,
    .rd_data_o,
    .snap_upt_o (snap_upt),
    .snap_sec_o (snap_sec)
  );

  logic unused_hit;
  assign unused_hit = upt_hit;
endmodule

// File: rtl/jt_checker.sv
module jt_checker #(
  parameter int UPT_W  = 32,
  parameter int SEC_W  = 48,
  parameter int RELOAD = 100,
  parameter int ADDR_W = 4,
  localparam int CNT_W = $clog2(RELOAD + 1),
  localparam int SEC_BASE = UPT_W / 8,
  localparam int SEC_TOP  = SEC_BASE + SEC_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              snap_i,
  input logic              upt_ovf_o,
  input logic              sec_ovf_o,
  input logic [UPT_W-1:0]  upt_i,
  input logic [SEC_W-1:0]  sec_i,
  input logic [CNT_W-1:0]  div_i,
  input logic [UPT_W-1:0]  snap_upt_i,
  input logic [SEC_W-1:0]  snap_sec_i
);
  logic acc, upt_wr, sec_wr;
  assign acc    = tick_i && !wr_en_i;
  assign upt_wr = wr_en_i && (int'(wr_addr_i) < SEC_BASE);
  assign sec_wr = wr_en_i && (int'(wr_addr_i) >= SEC_BASE) && (int'(wr_addr_i) < SEC_TOP);

  AST_UPT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !(&upt_i) |=> upt_i == $past(upt_i) + UPT_W'(1)); // R2
  AST_UPT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc && !upt_wr |=> $stable(upt_i)); // R9
  AST_SEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc && div_i == CNT_W'(1)) && !sec_wr |=> $stable(sec_i)); // R3
  AST_DIV_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |-> div_i != '0 && div_i <= CNT_W'(RELOAD)); // R3
  AST_UPT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && (&upt_i) |=> upt_i == '0 && upt_ovf_o); // R4
  AST_UPT_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upt_ovf_o |=> upt_ovf_o); // R4
  AST_SEC_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_ovf_o |=> sec_ovf_o); // R5
  AST_SNAP_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> snap_upt_i == $past(upt_i) && snap_sec_i == $past(sec_i)); // R6
  AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(snap_upt_i) && $stable(snap_sec_i)); // R6
  AST_DIV_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_wr |=> div_i == CNT_W'(RELOAD)); // R8
endmodule

bind jiffy_timekeeper jt_checker #(
  .UPT_W(UPT_W), .SEC_W(SEC_W), .RELOAD(RELOAD), .ADDR_W(ADDR_W)
) i_chk (
  .clk_i, .rst_ni, .tick_i, .wr_en_i, .wr_addr_i, .snap_i,
  .upt_ovf_o, .sec_ovf_o,
  .upt_i      (upt_q),
  .sec_i      (sec_q),
  .div_i      (div_q),
  .snap_upt_i (snap_upt),
  .snap_sec_i (snap_sec)
);

// File: tb/test_jiffy_timekeeper.sv
`timescale 1ns/10ps
module test_jiffy_timekeeper;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr_en = 1'b0, snap = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       upt_ovf, sec_ovf;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model
  longint unsigned m_u = 0, m_s = 0, m_su = 0, m_ss = 0;
  int  m_div = 100;
  bit  m_uo = 0, m_so = 0;

  always #4 clk = ~clk;

  jiffy_timekeeper i_jiffy_timekeeper (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .snap_i(snap),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .upt_ovf_o(upt_ovf), .sec_ovf_o(sec_ovf)
  );

  task automatic chk(input string req, input longint unsigned act, exp_v);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  function automatic longint unsigned exp_byte(input int a);
    if (a < 4)       return (m_su >> (8*a)) & 64'hFF;
    else if (a < 10) return (m_ss >> (8*(a-4))) & 64'hFF;
    else             return 0;
  endfunction

  // one clock with given stimulus; model updated at the edge, flags checked after
  task automatic cyc(input bit t, input bit w, input int a, input int d, input bit s);
    tick = t; wr_en = w; wr_addr = 4'(a); wr_data = 8'(d); snap = s;
    @(posedge clk);
    if (s) begin m_su = m_u; m_ss = m_s; end
    if (w) begin
      if (a < 4)
        m_u = (m_u & ~(64'hFF << (8*a))) | (longint'(d & 255) << (8*a));
      else if (a < 10) begin
        m_s = (m_s & ~(64'hFF << (8*(a-4)))) | (longint'(d & 255) << (8*(a-4)));
        m_div = 100;
      end
    end else if (t) begin
      if (m_u == 64'hFFFF_FFFF) begin m_u = 0; m_uo = 1; end else m_u++;
      if (m_div == 1) begin
        m_div = 100;
        if (m_s == 64'hFFFF_FFFF_FFFF) begin m_s = 0; m_so = 1; end else m_s++;
      end else m_div--;
    end
    @(negedge clk);
    tick = 0; wr_en = 0; snap = 0;
    chk("R4 upt_ovf", upt_ovf, m_uo);
    chk("R5 sec_ovf", sec_ovf, m_so);
  endtask

  task automatic ticks(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      cyc(1, 0, 0, 0, 0);
      if (gaps && (i % 3 == 1)) cyc(0, 0, 0, 0, 0);
    end
  endtask

  // reads all 16 byte addresses between edges (inputs idle)
  task automatic rd_all(input string req);
    for (int a = 0; a < 16; a++) begin
      rd_addr = 4'(a);
      #0.2;
      chk($sformatf("%s byte%0d", req, a), rd_data, exp_byte(a));
    end
  endtask

  task automatic snap_rd(input string req);
    cyc(0, 0, 0, 0, 1);
    rd_all(req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd_all("R1 reset");
    chk("R1 upt_ovf", upt_ovf, 0);
    chk("R1 sec_ovf", sec_ovf, 0);
    rst_n = 1'b1;
    snap_rd("R1 snap zero");

    ticks(37, 0);
    snap_rd("R2 after 37");
    ticks(62, 1);
    snap_rd("R3 after 99 no second");
    ticks(1, 0);
    snap_rd("R3 100th tick");

    cyc(1, 0, 0, 0, 1);
    rd_all("R6 snap with tick");
    ticks(5, 0);
    rd_all("R6 hold without snap");

    cyc(1, 1, 12, 8'hAA, 0);
    snap_rd("R9 tick with unmapped write");
    cyc(1, 1, 0, 8'h55, 0);
    cyc(1, 1, 2, 8'hC3, 0);
    snap_rd("R7 uptime byte writes");

    ticks(40, 0);
    cyc(1, 1, 5, 8'h12, 0);
    ticks(99, 1);
    snap_rd("R8 99 after seconds write");
    ticks(1, 0);
    snap_rd("R8 100 after seconds write");

    for (int a = 0; a < 4; a++) cyc(0, 1, a, 8'hFF, 0);
    ticks(1, 0);
    snap_rd("R4 uptime wrap");

    for (int a = 4; a < 10; a++) cyc(0, 1, a, 8'hFF, 0);
    ticks(100, 0);
    snap_rd("R5 seconds wrap");
    ticks(120, 1);
    snap_rd("R5 after wrap");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule